// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Unit

This block is a small arithmetic engine reached through a byte-wide register port. The host loads two 16-bit operands one byte at a time and picks an operation in a control register. Writing the upper byte of the second operand launches the chosen operation. Three operations exist: a signed 16×16 multiply, a divide of a signed dividend by an unsigned divisor, and a signed multiply-accumulate into a 40-bit sum that wraps and reports overflow. The host reads the 40-bit result back as five bytes, least significant byte first. A status byte carries the overflow flag and a busy flag.

Multiply and multiply-accumulate complete in the cycle of the launching write. The divide runs as a restoring divider that retires one quotient bit per clock. While it runs, the busy flag is set, result reads return the old value, and operand writes still land in the operand registers without disturbing the divide in flight. The register port has no back-pressure: every write is taken on the clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` combinationally from registered state.

Top module: `muldiv_acc`

## Requirements
- R1: After reset the result, overflow flag, busy flag, both operands and the operation select are all zero, so every readable offset returns 0x00.
- R2: A write to offset 0 loads the operation select from data bits [1:0] (0 multiply, 1 divide, 2 or 3 multiply-accumulate). When data bit 1 is set, the same write clears all 40 result bits. The overflow flag is left as it was.
- R3: Offsets 1 and 2 hold the low and high bytes of operand A. Offsets 3 and 4 hold the low and high bytes of operand B. A write to offset 4 while the unit is idle launches the selected operation, using the new high byte.
- R4: A multiply puts the signed product of A and B, sign-extended to 40 bits, in the result on the launching edge. It then clears B and keeps A. The overflow flag does not change.
- R5: A divide with non-zero B sets busy for 17 cycles. When busy drops, result bits [15:0] hold the quotient truncated toward zero, bits [31:16] hold the remainder in two's complement with the sign of the dividend, and bits [39:32] are zero. A and B are cleared on the launching edge.
- R6: A divide with B equal to zero writes a zero result on the launching edge, does not set busy, and clears both operands.
- R7: A multiply-accumulate adds the sign-extended product to the 40-bit result. The overflow flag is set when the true sum is negative or at least 2^40, and cleared otherwise. The result keeps the low 40 bits of the sum. B is cleared and A is kept.
- R8: Offsets 0 to 4 read result bytes 0 to 4, least significant first. Offset 5 reads overflow in bit 7, busy in bit 0 and zeros in bits [6:1]. Offsets 6 and 7 read 0x00.
- R9: While busy, result reads return the value from before the divide (or zero after a clearing control write). Operand writes are stored but do not change the divide in progress. A write to offset 4 stores the byte but launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read byte, combinational |

## Verification
The bench targets these corner cases:
- **Signs in the divide.** Negative dividends and the most negative dividend, divided by one and by the largest divisor. A design that divides signed by signed, or floors instead of truncating, gets the quotient and remainder wrong.
- **The accumulator edges.** A sum that goes below zero, and a sum that wraps through 2^40. A design that takes overflow only from the carry misses the negative case.
- **Operand handling.** Which operand each operation clears, and that a second launch reuses the operand it kept.
- **A busy divide.** Operand writes and launch attempts while the divide runs. A design that lets them through shows a changed result early, or a busy window of the wrong length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_A_LO = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_A_HI = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_B_LO = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_B_HI = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd5;

  localparam logic [1:0] SEL_MUL = 2'd0;
  localparam logic [1:0] SEL_DIV = 2'd1;
endpackage

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  den_q, rem_q, quo_q;
  logic          neg_q;
  logic [CW-1:0] cnt_q;

  logic [W:0]    rem_sh;
  logic [W+1:0]  diff;
  logic          fits;
  logic [W-1:0]  rem_n, quo_n;

  // one restoring step: shift in the next dividend bit, try subtracting
  always_comb begin
    rem_sh = {rem_q, quo_q[W-1]};
    diff   = {1'b0, rem_sh} - {2'b00, den_q};
    fits   = ~diff[W+1];
    rem_n  = fits ? diff[W-1:0] : rem_sh[W-1:0];
    quo_n  = {quo_q[W-2:0], fits};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      quot_o <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        rem_q <= rem_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          quot_o <= neg_q ? (~quo_n + 1'b1) : quo_n;
          rem_o  <= neg_q ? (~rem_n + 1'b1) : rem_n;
        end
      end else if (start_i) begin
        den_q  <= divisor_i;
        rem_q  <= '0;
        quo_q  <= dividend_i[W-1] ? (~dividend_i + 1'b1) : dividend_i;
        neg_q  <= dividend_i[W-1];
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end
    end
  end

  p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: rtl/muldiv_mac.sv
module muldiv_mac #(
  parameter int unsigned OPW  = 16,
  parameter int unsigned ACCW = 40
) (
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  input  logic [ACCW-1:0] acc_i,
  output logic [ACCW-1:0] prod_o,
  output logic [ACCW-1:0] sum_o,
  output logic            ovf_o
);
  localparam int unsigned PW = 2 * OPW;

  logic signed [PW-1:0] prod;
  logic [ACCW:0]        wide;

  always_comb begin
    prod   = $signed(a_i) * $signed(b_i);
    prod_o = {{(ACCW-PW){prod[PW-1]}}, prod};
    // one spare bit catches both wrap past the top and a negative sum
    wide   = {1'b0, acc_i} + {prod_o[ACCW-1], prod_o};
    sum_o  = wide[ACCW-1:0];
    ovf_o  = wide[ACCW];
  end
endmodule

// File: rtl/muldiv_acc.sv
module muldiv_acc
  import muldiv_pkg::*;
#(
  parameter int unsigned OPW  = 16,
  parameter int unsigned ACCW = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int unsigned HB = OPW / 2;
  localparam int unsigned NB = ACCW / 8;

  logic [1:0]      sel_q;
  logic [OPW-1:0]  a_q, b_q, b_full;
  logic [ACCW-1:0] res_q;
  logic            ovf_q;

  logic            div_busy, div_done, busy, launch;
  logic [OPW-1:0]  div_q, div_r;
  logic [ACCW-1:0] mac_prod, mac_sum;
  logic            mac_ovf;

  assign busy   = div_busy | div_done;
  assign b_full = {wr_data, b_q[HB-1:0]};
  assign launch = wr_en && (wr_addr == OFS_B_HI) && !busy;

  muldiv_mac #(.OPW(OPW), .ACCW(ACCW)) u_mac (
    .a_i(a_q), .b_i(b_full), .acc_i(res_q),
    .prod_o(mac_prod), .sum_o(mac_sum), .ovf_o(mac_ovf)
  );

  muldiv_divider #(.W(OPW)) u_div (
    .clk(clk), .rst_n(rst_n),
    .start_i(launch && (sel_q == SEL_DIV) && (b_full != '0)),
    .dividend_i(a_q), .divisor_i(b_full),
    .busy_o(div_busy), .done_o(div_done),
    .quot_o(div_q), .rem_o(div_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en) begin
        unique case (wr_addr)
          OFS_CTRL: begin
            sel_q <= wr_data[1:0];
            if (wr_data[1]) res_q <= '0;
          end
          OFS_A_LO: a_q[HB-1:0]   <= wr_data;
          OFS_A_HI: a_q[OPW-1:HB] <= wr_data;
          OFS_B_LO: b_q[HB-1:0]   <= wr_data;
          OFS_B_HI: begin
            if (!launch) begin
              b_q[OPW-1:HB] <= wr_data;
            end else if (sel_q == SEL_MUL) begin
              res_q <= mac_prod;
              b_q   <= '0;
            end else if (sel_q == SEL_DIV) begin
              if (b_full == '0) res_q <= '0;
              a_q <= '0;
              b_q <= '0;
            end else begin
              res_q <= mac_sum;
              ovf_q <= mac_ovf;
              b_q   <= '0;
            end
          end
          default: ;
        endcase
      end
      if (div_done) res_q <= {{(ACCW-2*OPW){1'b0}}, div_r, div_q};
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < ADDR_W'(NB)) rd_data = res_q[rd_addr*8 +: 8];
    else if (rd_addr == OFS_STAT) rd_data = {ovf_q, 6'b0, busy};
  end

  p_hold_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_done && !(wr_en && wr_addr == OFS_CTRL && wr_data[1]))
      |=> $stable(res_q));
  p_mul_keeps_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel_q == SEL_MUL) |=> (b_q == '0 && $stable(a_q) && $stable(ovf_q)));
  p_div_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel_q == SEL_DIV && b_full == '0) |=> (res_q == '0 && !busy));
  p_ovf_only_mac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && sel_q[1]) |=> $stable(ovf_q));
  p_div_clears_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && sel_q == SEL_DIV) |=> (a_q == '0 && b_q == '0));
  always_comb begin
    if (rst_n && rd_addr == OFS_STAT)
      a_stat_zero_r8: assert (rd_data[6:1] == 6'b0);
  end
endmodule

// File: tb/muldiv_acc_bench.sv
module muldiv_acc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  muldiv_acc u_muldiv_acc (.*);

  always #4 clk = ~clk;

  // behavioural reference state
  logic [39:0] m_res;
  logic [15:0] m_a, m_b;
  logic [1:0]  m_op;
  logic        m_ovf;
  int          m_cnt;
  logic [39:0] m_pend;
  string       cur_tag = "R1";

  function automatic logic [7:0] expect_rd(input logic [2:0] ra);
    if (ra < 3'd5) return m_res[ra*8 +: 8];
    if (ra == 3'd5) return {m_ovf, 6'b0, (m_cnt > 0)};
    return 8'h00;
  endfunction

  task automatic model_edge(input bit we, input logic [2:0] wa, input logic [7:0] wd);
    bit busy_pre, fin;
    longint prod, t;
    int sa, ub;
    busy_pre = (m_cnt > 0);
    fin = 0;
    if (m_cnt > 0) begin m_cnt--; fin = (m_cnt == 0); end
    if (we) begin
      case (wa)
        3'd0: begin m_op = wd[1:0]; if (wd[1]) m_res = '0; end
        3'd1: m_a[7:0] = wd;
        3'd2: m_a[15:8] = wd;
        3'd3: m_b[7:0] = wd;
        3'd4: begin
          m_b[15:8] = wd;
          if (!busy_pre) begin
            prod = longint'($signed(m_a)) * longint'($signed(m_b));
            if (m_op == 2'd0) begin
              m_res = prod[39:0]; m_b = '0;
            end else if (m_op == 2'd1) begin
              if (m_b == 0) m_res = '0;
              else begin
                sa = int'($signed(m_a));
                ub = int'({16'b0, m_b});
                m_pend = '0;
                m_pend[15:0]  = 16'(sa / ub);
                m_pend[31:16] = 16'(sa % ub);
                m_cnt = 17;
              end
              m_a = '0; m_b = '0;
            end else begin
              t = longint'(m_res) + prod;
              m_ovf = (t < 0) || (t >= (64'sd1 <<< 40));
              m_res = t[39:0];
              m_b = '0;
            end
          end
        end
        default: ;
      endcase
    end
    if (fin) m_res = m_pend;
  endtask

  // one clock: compare what is visible now, then drive and advance the model
  task automatic step(input bit we, input logic [2:0] wa, input logic [7:0] wd,
                      input logic [2:0] ra, input string tag);
    logic [7:0] e;
    @(negedge clk);
    e = expect_rd(rd_addr);
    n_run++;
    if (rd_data !== e) begin
      n_fail++;
      $display("FAIL %s: offset %0d read %02h expected %02h", cur_tag, rd_addr, rd_data, e);
    end
    cur_tag = tag;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    model_edge(we, wa, wd);
  endtask

  task automatic wr(input logic [2:0] wa, input logic [7:0] wd, input string tag);
    step(1'b1, wa, wd, 3'd5, tag);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < 8; i++) step(1'b0, '0, '0, 3'(i), tag);
  endtask

  task automatic set_ops(input logic [15:0] a, input logic [15:0] b, input string tag);
    wr(3'd1, a[7:0], tag); wr(3'd2, a[15:8], tag);
    wr(3'd3, b[7:0], tag); wr(3'd4, b[15:8], tag);
  endtask

  task automatic divide(input logic [15:0] a, input logic [15:0] b);
    wr(3'd0, 8'h01, "R5");
    set_ops(a, b, "R5");
    for (int i = 0; i < 20; i++) step(1'b0, '0, '0, 3'(i % 6), "R5");
    sweep("R5");
  endtask

  initial begin
    m_res = '0; m_a = '0; m_b = '0; m_op = '0; m_ovf = 0; m_cnt = 0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1");
    // R4 multiply: signed product, B cleared, A kept
    wr(3'd0, 8'h00, "R2");
    set_ops(16'hFFFD, 16'h0005, "R4");
    sweep("R4");
    wr(3'd4, 8'h01, "R4");   // reuses A=-3, B becomes 0x0100
    sweep("R4");
    set_ops(16'h8000, 16'h8000, "R4");
    sweep("R8");
    // R2 clearing control write
    wr(3'd0, 8'h02, "R2");
    sweep("R2");
    // R7 accumulate going negative, then wrapping back to zero
    set_ops(16'hFFFF, 16'h0001, "R7");
    sweep("R7");
    set_ops(16'h0001, 16'h0001, "R7");
    sweep("R7");
    set_ops(16'h0001, 16'h0001, "R7");
    sweep("R7");
    // R7 accumulate upward past 2^40
    wr(3'd0, 8'h03, "R7");
    wr(3'd1, 8'h00, "R7"); wr(3'd2, 8'h80, "R7");
    for (int i = 0; i < 1030; i++) begin
      wr(3'd3, 8'h00, "R7"); wr(3'd4, 8'h80, "R7");
    end
    sweep("R7");
    // R5 divides
    divide(16'hFFF9, 16'h0002);
    divide(16'd100, 16'd7);
    divide(16'h8000, 16'h0001);
    divide(16'h8000, 16'hFFFF);
    divide(16'h7FFF, 16'h0003);
    // R6 divide by zero
    wr(3'd0, 8'h01, "R6");
    set_ops(16'd1000, 16'h0000, "R6");
    sweep("R6");
    // R9 writes and launch attempt during a busy divide
    wr(3'd0, 8'h01, "R9");
    set_ops(16'd5000, 16'd9, "R9");
    wr(3'd1, 8'h11, "R9"); wr(3'd2, 8'h22, "R9");
    wr(3'd3, 8'h05, "R9"); wr(3'd4, 8'h00, "R9");
    for (int i = 0; i < 14; i++) step(1'b0, '0, '0, 3'(i % 6), "R9");
    sweep("R9");
    // after the divide, the operands written while busy are used
    wr(3'd0, 8'h00, "R3");
    wr(3'd4, 8'h00, "R3");
    sweep("R3");
    step(1'b0, '0, '0, 3'd0, "R8");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule